// File: doc/BRIEF.md
# Clock Output Gating Controller

This block sits between a free-running oscillator clock and a clock output pin. It divides the reference by one of four ratios and gates the divided clock with a single active-low control input. Three static settings shape its behaviour. A ratio select picks the divider. A role bit makes the control input either an output enable or a power-down request. A timing bit makes gating either immediate or aligned to the output's next falling edge.

The block runs on a clock at twice the reference frequency, so every output half-period is a whole number of cycles. In the enable role, the output driver is released and the oscillator keeps running. In the power-down role, an oscillator run request is also withdrawn. On exit from power-down the output stays off until a programmable number of restart ticks has been counted. The control input passes through a two-flop synchronizer. The immediate timing setting adds a combinational kill path around it.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: While rst_n is low, out_en and clk_out are 0 and osc_run is 1.
- R2: While enabled, clk_out has equal high and low phases. Each phase lasts 2^cfg_div_sel clk cycles (select 0,1,2,3 gives division by 1,2,4,8 of the reference, which is clk/2).
- R3: With cfg_pd_mode=0, a low ctl_n drives out_en and clk_out to 0 and leaves osc_run at 1.
- R4: With cfg_pd_mode=1, a low ctl_n drives osc_run, out_en and clk_out to 0.
- R5: With cfg_sync=0, a low ctl_n forces out_en and clk_out (and osc_run when cfg_pd_mode=1) to 0 at once, with no clk edge needed.
- R6: With cfg_sync=1, a low ctl_n takes effect only at the next falling edge of clk_out. The high pulse in progress keeps its full width, and out_en falls in the same cycle as clk_out.
- R7: With cfg_pd_mode=0, out_en rises on the third rising clk edge after ctl_n goes high. clk_out then stays low for one full half-period before its first rising edge.
- R8: With cfg_pd_mode=1, osc_run rises on the third rising clk edge after ctl_n goes high. out_en stays 0 until cfg_restart_ticks restart_tick pulses have been sampled, and rises on the edge after the last of them (one edge after osc_run when the count is 0).
- R9: A change of cfg_div_sel while enabled takes effect at the next falling edge of clk_out. A pulse already under way keeps the old width.
- R10: A low ctl_n during the restart wait returns the block to power-down (osc_run 0 on the third edge). A later restart counts its ticks from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the reference frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_n | input | 1 | Active-low control input, asynchronous |
| cfg_div_sel | input | SEL_W | Divider select: half-period of 2^value cycles |
| cfg_pd_mode | input | 1 | 0 selects the output-enable role, 1 selects the power-down role |
| cfg_sync | input | 1 | 1 aligns gating to a falling edge, 0 gates immediately |
| cfg_restart_ticks | input | TICK_W | Restart ticks to wait after power-down exit |
| restart_tick | input | 1 | Slow time-base pulse for the restart wait |
| clk_out | output | 1 | Gated divided clock, low when not driving |
| out_en | output | 1 | Enable for the output tristate driver |
| osc_run | output | 1 | Oscillator run request |

## Verification
Phase widths are measured for every ratio, both in a fixed sweep and in a random sequence of ratio changes. A ratio change made in the middle of a high pulse shows whether the new value is applied early or waits for the falling edge. The control input is dropped at the start of a long high pulse under both timing settings. Dropping it under synchronous timing separates a truncated pulse from a full one. Dropping it under immediate timing, and checking before any clock edge, separates the combinational kill path from the synchronized one. Restart waits are run with random tick counts and gaps, and one is interrupted part-way, to catch an off-by-one exit and a count that is not cleared.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ON      = 2'd1,
        ST_DOWN    = 2'd2,
        ST_RESTART = 2'd3
    } gate_state_e;

    typedef struct packed {
        gate_state_e st;
    } gate_regs_s;
endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkgate_div.sv
module clkgate_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             phase_o,
    output logic             fall_o
);
    localparam int NRAT  = 1 << SEL_W;
    localparam int CNT_W = NRAT - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic [SEL_W-1:0] sel;
    } div_regs_s;

    div_regs_s        d, q;
    logic [CNT_W-1:0] term_tab [NRAT];
    logic             at_term;

    // terminal count per ratio: half-period of 2^i cycles
    for (genvar g = 0; g < NRAT; g++) begin : g_term
        assign term_tab[g] = CNT_W'((1 << g) - 1);
    end

    assign at_term = (q.cnt == term_tab[q.sel]);

    always_comb begin
        d = q;
        if (!run_i) begin
            // idle: hold low phase, counter cleared, ratio tracks the select
            d.cnt   = '0;
            d.phase = 1'b0;
            d.sel   = sel_i;
        end else if (at_term) begin
            d.cnt   = '0;
            d.phase = ~q.phase;
            if (q.phase) d.sel = sel_i;   // new ratio only at a falling edge
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign phase_o = q.phase;
    assign fall_o  = run_i & q.phase & at_term;

    assert_half_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !at_term) |=> (!run_i || $stable(q.phase)));

    assert_ratio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !fall_o) |=> (!run_i || $stable(q.sel)));
endmodule

// File: rtl/clkgate_restart.sv
module clkgate_restart #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              tick_i,
    input  logic [TICK_W-1:0] limit_i,
    output logic              done_o
);
    logic [TICK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                        cnt_d = '0;
        else if (tick_i && (cnt_q != '1))   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q >= limit_i);

    assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/clkgate_fsm.sv
module clkgate_fsm import clkgate_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_i,      // synchronized, 1 = run
    input  logic        pd_mode_i,
    input  logic        sync_i,
    input  logic        fall_i,
    input  logic        done_i,
    output gate_state_e state_o
);
    gate_regs_s d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_ON: begin
                if (!ctl_i && (!sync_i || fall_i))
                    d.st = pd_mode_i ? ST_DOWN : ST_OFF;
            end
            ST_OFF: begin
                if (ctl_i)          d.st = ST_ON;
                else if (pd_mode_i) d.st = ST_DOWN;
            end
            ST_DOWN: begin
                if (ctl_i)          d.st = ST_RESTART;
                else if (!pd_mode_i) d.st = ST_OFF;
            end
            ST_RESTART: begin
                if (!ctl_i)     d.st = ST_DOWN;
                else if (done_i) d.st = ST_ON;
            end
            default: d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_OFF};
        else        q <= d;
    end

    assign state_o = q.st;

    assert_sync_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ON && sync_i && !fall_i) |=> (q.st == ST_ON));

    assert_restart_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RESTART && !done_i) |=> (q.st != ST_ON));

    assert_restart_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RESTART && !ctl_i) |=> (q.st == ST_DOWN));
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl import clkgate_pkg::*; #(
    parameter int SEL_W       = 2,
    parameter int TICK_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_n,
    input  logic [SEL_W-1:0]  cfg_div_sel,
    input  logic              cfg_pd_mode,
    input  logic              cfg_sync,
    input  logic [TICK_W-1:0] cfg_restart_ticks,
    input  logic              restart_tick,
    output logic              clk_out,
    output logic              out_en,
    output logic              osc_run
);
    logic        ctl_s;
    logic        phase, fall;
    logic        done;
    logic        kill;
    logic        is_on;
    gate_state_e state;

    clkgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_n),
        .sync_o  (ctl_s)
    );

    clkgate_div #(.SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (is_on),
        .sel_i   (cfg_div_sel),
        .phase_o (phase),
        .fall_o  (fall)
    );

    clkgate_restart #(.TICK_W(TICK_W)) u_restart (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state != ST_RESTART),
        .tick_i  (restart_tick),
        .limit_i (cfg_restart_ticks),
        .done_o  (done)
    );

    clkgate_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_i     (ctl_s),
        .pd_mode_i (cfg_pd_mode),
        .sync_i    (cfg_sync),
        .fall_i    (fall),
        .done_i    (done),
        .state_o   (state)
    );

    // immediate path: bypasses the synchronizer when timing is asynchronous
    assign kill    = ~cfg_sync & ~ctl_n;
    assign is_on   = (state == ST_ON);
    assign out_en  = is_on & ~kill;
    assign clk_out = phase & is_on & ~kill;
    assign osc_run = (state != ST_DOWN) & ~(kill & cfg_pd_mode);

    assert_drive_needs_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> osc_run);

    assert_oe_role_keeps_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pd_mode && $past(!cfg_pd_mode)) |-> osc_run);
endmodule

// File: tb/tb_clkout_gate_ctrl.sv
module tb_clkout_gate_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_n;
    logic [1:0] cfg_div_sel;
    logic       cfg_pd_mode;
    logic       cfg_sync;
    logic [7:0] cfg_restart_ticks;
    logic       restart_tick;
    logic       clk_out, out_en, osc_run;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    clkout_gate_ctrl dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .ctl_n             (ctl_n),
        .cfg_div_sel       (cfg_div_sel),
        .cfg_pd_mode       (cfg_pd_mode),
        .cfg_sync          (cfg_sync),
        .cfg_restart_ticks (cfg_restart_ticks),
        .restart_tick      (restart_tick),
        .clk_out           (clk_out),
        .out_en            (out_en),
        .osc_run           (osc_run)
    );

    function automatic int exp_half(input logic [1:0] sel);
        return 1 << sel;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise();
        int g = 0;
        while (clk_out !== 1'b0 && g < 100) begin @(negedge clk); g++; end
        while (clk_out !== 1'b1 && g < 200) begin @(negedge clk); g++; end
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        hi = 0;
        while (clk_out === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
        lo = 0;
        while (clk_out === 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    endtask

    // drop control at the first sample of a high pulse, synchronous timing
    task automatic sync_drop(input bit pd);
        int hi;
        bit en_ok, osc_ok;
        wait_rise();
        ctl_n = 1'b0;
        hi = 1; en_ok = 1; osc_ok = 1;
        @(negedge clk);
        while (clk_out === 1'b1 && hi < 40) begin
            if (out_en !== 1'b1) en_ok = 0;
            if (osc_run !== 1'b1) osc_ok = 0;
            hi++;
            @(negedge clk);
        end
        chk("R6 high pulse kept full width", hi, exp_half(cfg_div_sel));
        chk("R6 out_en held during pulse", en_ok, 1);
        chk("R6 osc_run held during pulse", osc_ok, 1);
        chk("R6 out_en falls with clk_out", out_en, 0);
        if (pd) chk("R4 osc_run off in power-down", osc_run, 0);
        else    chk("R3 osc_run kept in enable role", osc_run, 1);
    endtask

    task automatic drop_and_wait_off();
        ctl_n = 1'b0;
        for (int i = 0; i < 64 && osc_run === 1'b1; i++) @(negedge clk);
        chk("R4 power-down reached", osc_run, 0);
        chk("R4 output off in power-down", {out_en, clk_out}, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
    endtask

    initial begin
        #(4 * 150000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int hi, lo, n, gap;
        void'($urandom(32'd7321));
        rst_n = 1'b0; ctl_n = 1'b1; cfg_div_sel = 2'd2; cfg_pd_mode = 1'b0;
        cfg_sync = 1'b1; cfg_restart_ticks = 8'd3; restart_tick = 1'b0;

        cyc(3);
        chk("R1 out_en in reset", out_en, 0);
        chk("R1 clk_out in reset", clk_out, 0);
        chk("R1 osc_run in reset", osc_run, 1);

        rst_n = 1'b1;
        cyc(2);
        chk("R7 out_en still off after two edges", out_en, 0);
        cyc(1);
        chk("R7 out_en on at third edge", out_en, 1);
        chk("R7 clk_out starts low", clk_out, 0);

        // R2: each ratio in turn
        for (int s = 0; s < 4; s++) begin
            cfg_div_sel = 2'(s);
            measure(hi, lo);
            measure(hi, lo);
            chk("R2 high phase width", hi, exp_half(2'(s)));
            chk("R2 low phase width", lo, exp_half(2'(s)));
        end

        // R2/R9: random ratio sequence
        for (int k = 0; k < 8; k++) begin
            cfg_div_sel = 2'($urandom_range(0, 3));
            measure(hi, lo);
            measure(hi, lo);
            chk("R2 random high width", hi, exp_half(cfg_div_sel));
            chk("R2 random low width", lo, exp_half(cfg_div_sel));
        end

        // R9: ratio change mid-pulse
        cfg_div_sel = 2'd3;
        measure(hi, lo);
        wait_rise();
        hi = 1;
        @(negedge clk); hi++;
        cfg_div_sel = 2'd0;
        @(negedge clk);
        while (clk_out === 1'b1 && hi < 40) begin hi++; @(negedge clk); end
        lo = 0;
        while (clk_out === 1'b0 && lo < 40) begin lo++; @(negedge clk); end
        chk("R9 pulse under way keeps old width", hi, 8);
        chk("R9 new ratio after falling edge", lo, 1);

        // R6/R3: synchronous disable, enable role
        cfg_div_sel = 2'd2;
        measure(hi, lo);
        sync_drop(1'b0);
        cyc(4);
        chk("R3 stays disabled", {out_en, clk_out}, 0);
        chk("R3 oscillator kept", osc_run, 1);

        // R7: re-enable
        ctl_n = 1'b1;
        cyc(2);
        chk("R7 no drive before third edge", out_en, 0);
        cyc(1);
        chk("R7 drive at third edge", out_en, 1);
        lo = 0;
        while (clk_out === 1'b0 && lo < 40) begin lo++; @(negedge clk); end
        hi = 0;
        while (clk_out === 1'b1 && hi < 40) begin hi++; @(negedge clk); end
        chk("R7 first low phase full", lo, 4);
        chk("R7 first high pulse full", hi, 4);

        // R5/R3: asynchronous disable, enable role
        cfg_sync = 1'b0;
        wait_rise();
        ctl_n = 1'b0;
        #1;
        chk("R5 clk_out killed at once", clk_out, 0);
        chk("R5 out_en killed at once", out_en, 0);
        chk("R3 osc_run kept on async disable", osc_run, 1);
        cyc(4);
        chk("R3 still disabled", out_en, 0);

        // R4/R6: synchronous power-down
        cfg_sync = 1'b1;
        ctl_n = 1'b1;
        cyc(3);
        chk("R7 re-enabled", out_en, 1);
        cfg_pd_mode = 1'b1;
        measure(hi, lo);
        sync_drop(1'b1);

        // R8: restart wait of three ticks
        cyc(2);
        ctl_n = 1'b1;
        cyc(2);
        chk("R8 oscillator still off", osc_run, 0);
        cyc(1);
        chk("R8 oscillator requested", osc_run, 1);
        chk("R8 no drive before ticks", out_en, 0);
        for (int k = 0; k < 2; k++) begin
            restart_tick = 1'b1; @(negedge clk); restart_tick = 1'b0; cyc(2);
        end
        cyc(5);
        chk("R8 no drive after two ticks", out_en, 0);
        restart_tick = 1'b1; @(negedge clk); restart_tick = 1'b0;
        chk("R8 no drive on last tick edge", out_en, 0);
        @(negedge clk);
        chk("R8 drive after last tick", out_en, 1);
        chk("R8 clk_out starts low", clk_out, 0);
        drop_and_wait_off();

        // R10: abort a restart
        ctl_n = 1'b1;
        cyc(3);
        restart_tick = 1'b1; @(negedge clk); restart_tick = 1'b0;
        ctl_n = 1'b0;
        cyc(2);
        chk("R10 oscillator until abort takes hold", osc_run, 1);
        cyc(1);
        chk("R10 aborted to power-down", osc_run, 0);
        ctl_n = 1'b1;
        cyc(3);
        for (int k = 0; k < 2; k++) begin
            restart_tick = 1'b1; @(negedge clk); restart_tick = 1'b0; @(negedge clk);
        end
        cyc(3);
        chk("R10 tick count restarted", out_en, 0);
        ctl_n = 1'b0;
        cyc(3);
        chk("R10 back to power-down", osc_run, 0);

        // R8: random tick counts and gaps
        for (int k = 0; k < 6; k++) begin
            n = $urandom_range(0, 4);
            cfg_restart_ticks = 8'(n);
            cfg_div_sel = 2'($urandom_range(0, 3));
            ctl_n = 1'b1;
            cyc(3);
            for (int t = 0; t < n; t++) begin
                gap = $urandom_range(0, 3);
                cyc(gap);
                restart_tick = 1'b1; @(negedge clk); restart_tick = 1'b0;
            end
            chk("R8 random: off until count reached", out_en, 0);
            @(negedge clk);
            chk("R8 random: on after count reached", out_en, 1);
            drop_and_wait_off();
        end

        // R5/R4: asynchronous power-down
        cfg_restart_ticks = 8'd0;
        cfg_div_sel = 2'd1;
        ctl_n = 1'b1;
        cyc(4);
        chk("R8 zero-tick restart drives", out_en, 1);
        cfg_sync = 1'b0;
        wait_rise();
        ctl_n = 1'b0;
        #1;
        chk("R5 osc_run dropped at once", osc_run, 0);
        chk("R5 output dropped at once", {out_en, clk_out}, 0);
        cyc(4);
        chk("R4 power-down held", {osc_run, out_en, clk_out}, 0);

        summary();
        $finish;
    end
endmodule